// File: doc/BRIEF.md
# Firmware Image Structure and Checksum Validator

This block examines a firmware update image held in a word-addressed memory before anything else is allowed to use it. After a start strobe it reads the image one 32-bit word at a time from address 0 upward. It checks the header fields, the size arithmetic, the optional trailing table of alternate signatures, and three separate wrapping checksums. It then reports a single pass flag and a 3-bit reason code that names the first rule the image broke.

The header is 12 words long and its fields sit at fixed word indices: word 0 loader version, word 1 header format version, word 2 signature, word 3 platform mask, word 4 checksum, word 6 data size in bytes, word 7 total size in bytes. Words 5 and 8 to 11 are not interpreted. The data region follows the header. Any bytes past header plus data form the signature table. The table starts with five words: word 0 is the entry count, word 1 is the table checksum, and words 2 to 4 are not interpreted. Three-word entries follow, each holding signature, platform mask and checksum in that order.

Reads are issued on a one-cycle-latency memory port and return in order. The scan stops as soon as the result is known. A caller pulses `start`, waits for the one-cycle `done` pulse, and then reads `pass` and `err_code`. Both stay valid until the next result.

Top module: `fwimg_check`

## Requirements
- R1: If data bytes + 48 is greater than the total bytes, the result is code 1 (size), after exactly 12 reads.
- R2: A loader version other than 1, or a header format version other than `hdr_type` (sampled at start), gives code 2 (format), after exactly 12 reads.
- R3: The table size is total bytes − (48 + data bytes). When it is non-zero, it must be at least 20 and (size − 20) must be a multiple of 12; otherwise the result is code 3, after exactly 12 reads. A table of exactly 20 bytes (count 0) is legal.
- R4: If the table size differs from count × 12 + 20 (computed without overflow), the result is code 4. The scan stops once the count word returns, for a total of (48 + data bytes)/4 + 1 reads.
- R5: The 32-bit wrapping sum of all table words must be zero; otherwise the result is code 5.
- R6: The 32-bit wrapping sum of all header and data words must be zero; otherwise the result is code 6.
- R7: For every table entry, (entry sig + pf + cksum) must equal (header sig + pf + cksum) modulo 2^32; otherwise the result is code 7.
- R8: When several rules are broken, the reported code is the lowest-numbered broken rule among codes 1 to 7.
- R9: A data size field of 0 means 2000 data bytes and 2048 total bytes; the total size field is then ignored.
- R10: `done` is a one-cycle pulse. `pass` is 1 exactly when `err_code` is 0. Both hold until the next `done`. A `start` while `busy` is ignored. After reset, `busy`, `done`, `pass` and `err_code` are all 0.
- R11: Reads use ascending word addresses from 0, and each read's data returns one cycle later. A passing image takes exactly total bytes / 4 reads. No read is issued while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| hdr_type | input | 32 | Required header format version |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Word address of the read |
| mem_rd_data | input | 32 | Read data, one cycle after the request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Image accepted |
| err_code | output | 3 | 0 pass, 1 size, 2 format, 3 table shape, 4 table size, 5 table sum, 6 main sum, 7 entry |

## Verification
The hardest outcome to reach from the ports is an entry-relation failure (code 7) with every other rule intact. Corrupting one entry word also breaks the table sum, which outranks it. The stimulus therefore bumps an entry's signature and lowers the table checksum word by the same amount, so the table still sums to zero. The same approach, corrupting two regions with independently recomputed sums, drives the priority cases. The count-mismatch case also checks the exact number of reads, which shows that the scan stops early.

// File: rtl/fwimg_pkg.sv
package fwimg_pkg;
  localparam int unsigned HDR_WORDS     = 12;
  localparam int unsigned HDR_BYTES     = HDR_WORDS * 4;
  localparam int unsigned TBL_HDR_WORDS = 5;
  localparam int unsigned TBL_HDR_BYTES = TBL_HDR_WORDS * 4;
  localparam int unsigned ENT_WORDS     = 3;
  localparam int unsigned ENT_BYTES     = ENT_WORDS * 4;
  localparam int unsigned IDX_W         = 30;

  // header word positions
  localparam int unsigned F_LDR  = 0;
  localparam int unsigned F_HVER = 1;
  localparam int unsigned F_SIG  = 2;
  localparam int unsigned F_PF   = 3;
  localparam int unsigned F_CK   = 4;
  localparam int unsigned F_DSZ  = 6;
  localparam int unsigned F_TSZ  = 7;

  typedef enum logic [2:0] {
    E_NONE, E_SIZE, E_FMT, E_TSHAPE, E_TSIZE, E_TSUM, E_MSUM, E_ENTRY
  } fail_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_CHK, S_BODY, S_FIN
  } phase_e;
endpackage

// File: rtl/fwimg_fetch.sv
module fwimg_fetch
  import fwimg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             halt,
  input  logic [IDX_W-1:0] lim,
  output logic             rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic             vld,
  output logic [IDX_W-1:0] vidx
);
  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] vidx_q, vidx_d;
  logic             vld_q;

  always_comb begin
    rd_en  = act_q && !halt && (idx_q < lim);
    act_d  = act_q;
    idx_d  = idx_q;
    vidx_d = vidx_q;
    if (go) begin
      act_d = 1'b1;
      idx_d = '0;
    end else begin
      if (halt) act_d = 1'b0;
      if (rd_en) begin
        idx_d  = idx_q + 1'b1;
        vidx_d = idx_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      vidx_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      vidx_q <= vidx_d;
      vld_q  <= rd_en;
    end
  end

  assign rd_addr = idx_q[ADDR_W-1:0];
  assign vld     = vld_q;
  assign vidx    = vidx_q;

  // R11: consecutive reads walk the image one word at a time
  p_addr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> idx_q == $past(idx_q) + 1'b1);
  // R11: each read returns exactly one cycle later, tagged with its index
  p_read_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> vld && (vidx == $past(idx_q)));
endmodule

// File: rtl/fwimg_sums.sv
module fwimg_sums
  import fwimg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             vld,
  input  logic [IDX_W-1:0] vidx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] main_words,
  input  logic [31:0]      ref_sum,
  output logic             main_nz,
  output logic             tbl_nz,
  output logic             ent_bad
);
  logic [31:0] msum_q, msum_d, tsum_q, tsum_d, acc_q, acc_d;
  logic [2:0]  ecnt_q, ecnt_d;
  logic [1:0]  slot_q, slot_d;
  logic        bad_q, bad_d;
  logic        in_main;

  always_comb begin
    in_main = vidx < main_words;
    msum_d = msum_q;
    tsum_d = tsum_q;
    acc_d  = acc_q;
    ecnt_d = ecnt_q;
    slot_d = slot_q;
    bad_d  = bad_q;
    if (clr) begin
      msum_d = '0;
      tsum_d = '0;
      acc_d  = '0;
      ecnt_d = '0;
      slot_d = '0;
      bad_d  = 1'b0;
    end else if (vld) begin
      if (in_main) begin
        msum_d = msum_q + wdata;
      end else begin
        tsum_d = tsum_q + wdata;
        if (ecnt_q < 3'(TBL_HDR_WORDS)) begin
          ecnt_d = ecnt_q + 1'b1;
        end else begin
          unique case (slot_q)
            2'd0: begin acc_d = wdata;         slot_d = 2'd1; end
            2'd1: begin acc_d = acc_q + wdata; slot_d = 2'd2; end
            default: begin
              if ((acc_q + wdata) != ref_sum) bad_d = 1'b1;
              slot_d = 2'd0;
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msum_q <= '0;
      tsum_q <= '0;
      acc_q  <= '0;
      ecnt_q <= '0;
      slot_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      msum_q <= msum_d;
      tsum_q <= tsum_d;
      acc_q  <= acc_d;
      ecnt_q <= ecnt_d;
      slot_q <= slot_d;
      bad_q  <= bad_d;
    end
  end

  assign main_nz = msum_q != 32'd0;
  assign tbl_nz  = tsum_q != 32'd0;
  assign ent_bad = bad_q;

  // R7: a failing entry stays recorded for the rest of the scan
  p_entry_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q && !clr |=> bad_q);
  // R5: the table sum moves only on returned words
  p_tbl_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vld && !clr |=> $stable(tsum_q));
endmodule

// File: rtl/fwimg_ctrl.sv
module fwimg_ctrl
  import fwimg_pkg::*;
#(
  parameter int unsigned DEF_DATA_BYTES = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      hdr_type,
  input  logic             vld,
  input  logic [IDX_W-1:0] vidx,
  input  logic [31:0]      wdata,
  input  logic             main_nz,
  input  logic             tbl_nz,
  input  logic             ent_bad,
  output logic             go,
  output logic             halt,
  output logic [IDX_W-1:0] lim,
  output logic [IDX_W-1:0] main_words,
  output logic [31:0]      ref_sum,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [2:0]       err_code
);
  localparam logic [31:0] DEF_TOTAL = 32'(DEF_DATA_BYTES + HDR_BYTES);

  phase_e st_q, st_d;
  logic [31:0] typ_q, typ_d, ldr_q, ldr_d, hver_q, hver_d;
  logic [31:0] sig_q, sig_d, pf_q, pf_d, ck_q, ck_d, dsz_q, dsz_d, tsz_q, tsz_d;
  logic        done_q, done_d, pass_q, pass_d;
  fail_e       err_q, err_d;

  logic [31:0]      data_bytes, total_bytes, ext_bytes;
  logic [32:0]      end_main;
  logic [IDX_W-1:0] mw_calc, total_words;
  logic             size_bad, fmt_bad, shape_bad, count_bad, fail_now;
  logic [39:0]      count_bytes;
  fail_e            fail_code;

  // size arithmetic from captured header fields
  always_comb begin
    data_bytes  = (dsz_q == 32'd0) ? 32'(DEF_DATA_BYTES) : dsz_q;
    total_bytes = (dsz_q == 32'd0) ? DEF_TOTAL : tsz_q;
    end_main    = {1'b0, data_bytes} + 33'(HDR_BYTES);
    ext_bytes   = total_bytes - end_main[31:0];
    mw_calc     = end_main[IDX_W+1:2];
    total_words = total_bytes[IDX_W+1:2];
    size_bad    = end_main > {1'b0, total_bytes};
    fmt_bad     = (ldr_q != 32'd1) || (hver_q != typ_q);
    shape_bad   = (ext_bytes != 32'd0) &&
                  ((ext_bytes < 32'(TBL_HDR_BYTES)) ||
                   (((ext_bytes - 32'(TBL_HDR_BYTES)) % 32'(ENT_BYTES)) != 32'd0));
    count_bytes = ({8'd0, wdata} * 40'(ENT_BYTES)) + 40'(TBL_HDR_BYTES);
    count_bad   = (ext_bytes != 32'd0) && (count_bytes != {8'd0, ext_bytes});
  end

  // next-state process
  always_comb begin
    st_d   = st_q;
    typ_d  = typ_q;
    ldr_d  = ldr_q;  hver_d = hver_q; sig_d = sig_q; pf_d = pf_q;
    ck_d   = ck_q;   dsz_d  = dsz_q;  tsz_d = tsz_q;
    done_d = 1'b0;
    pass_d = pass_q;
    err_d  = err_q;
    fail_now  = 1'b0;
    fail_code = E_NONE;
    go = 1'b0;

    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          go    = 1'b1;
          typ_d = hdr_type;
          st_d  = S_HDR;
        end
      end
      S_HDR: begin
        if (vld) begin
          if (vidx == IDX_W'(F_LDR))  ldr_d  = wdata;
          if (vidx == IDX_W'(F_HVER)) hver_d = wdata;
          if (vidx == IDX_W'(F_SIG))  sig_d  = wdata;
          if (vidx == IDX_W'(F_PF))   pf_d   = wdata;
          if (vidx == IDX_W'(F_CK))   ck_d   = wdata;
          if (vidx == IDX_W'(F_DSZ))  dsz_d  = wdata;
          if (vidx == IDX_W'(F_TSZ))  tsz_d  = wdata;
          if (vidx == IDX_W'(HDR_WORDS - 1)) st_d = S_CHK;
        end
      end
      S_CHK: begin
        if (size_bad)       begin fail_now = 1'b1; fail_code = E_SIZE;   end
        else if (fmt_bad)   begin fail_now = 1'b1; fail_code = E_FMT;    end
        else if (shape_bad) begin fail_now = 1'b1; fail_code = E_TSHAPE; end
        else if (total_words <= IDX_W'(HDR_WORDS)) st_d = S_FIN;
        else st_d = S_BODY;
      end
      S_BODY: begin
        if (vld) begin
          if ((vidx == mw_calc) && count_bad) begin
            fail_now  = 1'b1;
            fail_code = E_TSIZE;
          end else if (vidx == total_words - 1'b1) begin
            st_d = S_FIN;
          end
        end
      end
      S_FIN: begin
        st_d   = S_IDLE;
        done_d = 1'b1;
        if (tbl_nz)       err_d = E_TSUM;
        else if (main_nz) err_d = E_MSUM;
        else if (ent_bad) err_d = E_ENTRY;
        else              err_d = E_NONE;
        pass_d = !tbl_nz && !main_nz && !ent_bad;
      end
      default: st_d = S_IDLE;
    endcase

    if (fail_now) begin
      st_d   = S_IDLE;
      done_d = 1'b1;
      pass_d = 1'b0;
      err_d  = fail_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      typ_q <= '0; ldr_q <= '0; hver_q <= '0; sig_q <= '0;
      pf_q  <= '0; ck_q  <= '0; dsz_q  <= '0; tsz_q <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      err_q  <= E_NONE;
    end else begin
      st_q  <= st_d;
      typ_q <= typ_d; ldr_q <= ldr_d; hver_q <= hver_d; sig_q <= sig_d;
      pf_q  <= pf_d;  ck_q  <= ck_d;  dsz_q  <= dsz_d;  tsz_q <= tsz_d;
      done_q <= done_d;
      pass_q <= pass_d;
      err_q  <= err_d;
    end
  end

  assign halt       = fail_now || (st_q == S_FIN);
  assign lim        = (st_q == S_HDR) ? IDX_W'(HDR_WORDS) : total_words;
  assign main_words = (st_q == S_HDR) ? IDX_W'(HDR_WORDS) : mw_calc;
  assign ref_sum    = sig_q + pf_q + ck_q;
  assign busy       = st_q != S_IDLE;
  assign done       = done_q;
  assign pass       = pass_q;
  assign err_code   = err_q;

  // R10: pass agrees with the reason code on every result
  p_pass_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pass == (err_code == 3'd0));
  // R10: the result strobe lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: the reported code changes only together with a result
  p_code_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(err_code));
  // R8: a header-stage rejection never leaves the scan running
  p_hdr_reject_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CHK) && (size_bad || fmt_bad || shape_bad) |=> !busy && done);
endmodule

// File: rtl/fwimg_check.sv
module fwimg_check
  import fwimg_pkg::*;
#(
  parameter int          ADDR_W         = 16,
  parameter int unsigned DEF_DATA_BYTES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       hdr_type,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [2:0]        err_code
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic             go, halt, vld, main_nz, tbl_nz, ent_bad;
  logic [IDX_W-1:0] lim, vidx, main_words;
  logic [31:0]      ref_sum;

  fwimg_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n_i), .go(go), .halt(halt), .lim(lim),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .vld(vld), .vidx(vidx)
  );

  fwimg_sums u_sums (
    .clk(clk), .rst_n(rst_n_i), .clr(go), .vld(vld), .vidx(vidx),
    .wdata(mem_rd_data), .main_words(main_words), .ref_sum(ref_sum),
    .main_nz(main_nz), .tbl_nz(tbl_nz), .ent_bad(ent_bad)
  );

  fwimg_ctrl #(.DEF_DATA_BYTES(DEF_DATA_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .start(start), .hdr_type(hdr_type),
    .vld(vld), .vidx(vidx), .wdata(mem_rd_data),
    .main_nz(main_nz), .tbl_nz(tbl_nz), .ent_bad(ent_bad),
    .go(go), .halt(halt), .lim(lim), .main_words(main_words), .ref_sum(ref_sum),
    .busy(busy), .done(done), .pass(pass), .err_code(err_code)
  );

  // R11: the memory is left alone between scans
  p_no_read_idle_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    !busy |-> !mem_rd_en);
endmodule

// File: tb/tb_fwimg_check.sv
module tb_fwimg_check;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       hdr_type = 32'd1;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [31:0]       mem_rd_data = '0;
  logic              busy, done, pass;
  logic [2:0]        err_code;

  always #4 clk = ~clk;

  fwimg_check #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hdr_type(hdr_type),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .pass(pass), .err_code(err_code)
  );

  logic [31:0] mem [0:1023];
  int rdcnt = 0;
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_addr[9:0]];
      rdcnt <= rdcnt + 1;
    end
  end

  int nchk = 0, nfail = 0;
  int q_code[$], q_rd[$];
  string q_tag[$];
  int rd_base = 0;
  int seed = 1;
  int last_code = 0;

  // monitor: compares each result against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_code.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R10 unexpected done: got code %0d expected no result", err_code);
      end else begin
        int ec, er;
        string tg;
        ec = q_code.pop_front(); er = q_rd.pop_front(); tg = q_tag.pop_front();
        nchk++;
        if (err_code !== 3'(ec) || pass !== (ec == 0)) begin
          nfail++;
          $display("FAIL %s code/pass: got %0d/%0b expected %0d/%0b", tg, err_code, pass, ec, ec == 0);
        end
        if (er >= 0) begin
          nchk++;
          if (rdcnt - rd_base != er) begin
            nfail++;
            $display("FAIL R11 (%s) reads: got %0d expected %0d", tg, rdcnt - rd_base, er);
          end
        end
        last_code = ec;
      end
    end
  end

  function automatic logic [31:0] rnd(input int i);
    return (32'h9E37_79B9 * 32'(i + seed)) ^ (32'(seed) << 7);
  endfunction

  task automatic finalize(input int mw, input int nent);
    logic [31:0] s, r;
    mem[4] = '0;
    s = '0;
    for (int i = 0; i < mw; i++) s += mem[i];
    mem[4] = -s;
    if (nent >= 0) begin
      r = mem[2] + mem[3] + mem[4];
      for (int k = 0; k < nent; k++)
        mem[mw+5+3*k+2] = r - mem[mw+5+3*k] - mem[mw+5+3*k+1];
      mem[mw+1] = '0;
      s = '0;
      for (int i = mw; i < mw + 5 + 3*nent; i++) s += mem[i];
      mem[mw+1] = -s;
    end
  endtask

  // builds a clean image: 12 header words, dw data words, optional table
  task automatic build(input int dw, input int nent);
    int mw, tw;
    mw = 12 + dw;
    tw = mw + ((nent >= 0) ? 5 + 3*nent : 0);
    for (int i = 0; i < tw; i++) mem[i] = rnd(i);
    seed++;
    mem[0] = 32'd1;
    mem[1] = 32'd1;
    mem[6] = 32'(dw * 4);
    mem[7] = 32'(tw * 4);
    if (nent >= 0) mem[mw] = 32'(nent);
    finalize(mw, nent);
  endtask

  // driver: pushes the expectation, pulses start, waits for the monitor
  task automatic run(input int code, input int reads, input string tag);
    q_code.push_back(code); q_rd.push_back(reads); q_tag.push_back(tag);
    @(negedge clk);
    rd_base = rdcnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q_code.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string msg, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", msg, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && pass === 1'b0 && err_code === 3'd0,
        "R10 reset state", int'({busy, done, pass, err_code}), 0);
    chk(mem_rd_en === 1'b0, "R11 idle reads", int'(mem_rd_en), 0);

    build(16, -1);  run(0, 28, "R6 plain pass");
    build(10, 2);   run(0, 33, "R7 two entries pass");
    build(4, 0);    run(0, 21, "R3 empty table pass");

    build(500, -1); mem[6] = '0; mem[7] = 32'hDEAD_0001; finalize(512, -1);
    run(0, 512, "R9 default size");

    build(16, -1); mem[6] = 32'd100;            run(1, 12, "R1 size");
    build(8, -1);  mem[0] = 32'd2;              run(2, 12, "R2 loader version");
    build(8, -1);  hdr_type = 32'd3;            run(2, 12, "R2 header type");
    hdr_type = 32'd1;
    build(8, -1);  mem[7] = mem[7] + 32'd8;     run(3, 12, "R3 short table");
    build(8, -1);  mem[7] = mem[7] + 32'd26;    run(3, 12, "R3 ragged table");
    build(8, 2);   mem[20] = 32'd3;             run(4, 21, "R4 count mismatch");
    build(8, 2);   mem[23] = mem[23] + 32'd1;   run(5, 31, "R5 table sum");
    build(8, 2);   mem[15] = mem[15] + 32'd1;   run(6, 31, "R6 main sum");
    build(8, 2);   mem[28] = mem[28] + 32'd1; mem[21] = mem[21] - 32'd1;
    run(7, 31, "R7 entry relation");
    build(8, 2);   mem[15] = mem[15] + 32'd1; mem[23] = mem[23] + 32'd1;
    run(5, 31, "R8 table sum over main sum");
    build(8, -1);  mem[6] = 32'd1000; mem[0] = 32'd7;
    run(1, 12, "R8 size over format");

    // R10: a second start while busy must not produce a second result
    build(40, 1);
    q_code.push_back(0); q_rd.push_back(-1); q_tag.push_back("R10 start while busy");
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b1, "R10 busy mid-scan", int'(busy), 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (q_code.size() != 0) @(negedge clk);
    repeat (80) @(negedge clk);
    chk(busy === 1'b0, "R10 idle after single result", int'(busy), 0);

    // R10: result held until the next scan
    build(8, -1); mem[0] = 32'd5; run(2, 12, "R2 held code source");
    repeat (20) @(negedge clk);
    chk(err_code === 3'(last_code) && pass === 1'b0, "R10 result held",
        int'(err_code), last_code);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule